// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a serial-management-bus target that holds a small eight-entry byte register file for a clock fan-out device. A host writes it with an indexed block transfer: after the target address, the host sends a starting index, then a byte count, then that many data bytes. These land in consecutive registers. A read starts the same way with the write address and an index. The host then issues a repeated start and the read address. The target answers with the current value of its byte-count register, followed by register contents from the index onward, until the host refuses a byte.

SCL and SDA come in as open-drain line levels and pass through synchronizers in a fast system clock. The target pulls SDA low through a single pull-down enable. Its bus address is picked by a two-bit code from a three-level select pin. The register contents drive the per-output enables and the two loop-mode selections. Pin readbacks and power-up straps come in as plain inputs.

Top module: `smb_idx_slave`

## Requirements
- R1: The 7-bit address compared against is 0x6E for select code 2'b00, 0x6B for 2'b01, and 0x6A for 2'b10 or 2'b11. These correspond to write/read bytes 0xDC/0xDD, 0xD6/0xD7 and 0xD4/0xD5. On a mismatch the target gives no acknowledge and leaves SDA released until the next start.
- R2: In a write, the index byte (low 3 bits used) and the count byte are each acknowledged. The next count data bytes are stored at the index and the indices after it, and each is acknowledged.
- R3: Data bytes sent after the count is used up are acknowledged and discarded.
- R4: After the read address, the target sends the byte-count register (index 7) first, then register bytes starting at the index. It continues while the host acknowledges, and releases SDA after the host's not-acknowledge.
- R5: The index advances modulo 8 on writes and reads, so index 7 is followed by index 0.
- R6: After reset, index 1 reads 0xFF, index 2 reads 0x0F, index 6 reads 0xC0 and index 7 reads 0x07. Index 0 reads {bandwidth strap, loop strap, 6'b0}, with the straps sampled while reset is high.
- R7: Index 5 always reads 0x21 (revision 2 in bits 7:4, vendor 1 in bits 3:0). Writes to indices 3, 4 and 5 and to bits 7:4 of index 2 have no effect; those bits of index 2 read 0.
- R8: Index 3 reads the active-low enable pins 7..0. Index 4 reads {4'b0, pins 11..8}.
- R9: Output enable i is high exactly when enable bit i (index 1 bits 7:0, index 2 bits 3:0) is 1 and pin i is 0. The result is registered one clock after the inputs. bw_low follows index 0 bit 7 (0 = high bandwidth), and pll_mode follows index 0 bit 6 (0 = bypass, 1 = loop).
- R10: Start and stop are SDA edges while SCL is high. The target changes SDA only while the synchronized SCL is low, and never drives SDA when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20x SCL |
| rst | input | 1 | Synchronous active-high reset; straps are latched while it is high |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 = pull SDA low |
| adr_code | input | 2 | Address select code: 00 low, 01 mid, 10/11 high |
| oe_pin_n | input | 12 | Active-low per-output enable pins |
| strap_bw | input | 1 | Bandwidth strap (0 = high bandwidth) |
| strap_pll | input | 1 | Loop strap (0 = bypass, 1 = loop) |
| out_en | output | 12 | Combined per-output enable |
| bw_low | output | 1 | Bandwidth selection from index 0 bit 7 |
| pll_mode | output | 1 | Loop selection from index 0 bit 6 |

## Verification
The block is driven by a bus-level host model with a wired-AND data line. Transfers cover reset defaults read in one long block, a two-byte write and its readback, and a write whose run crosses from index 7 to index 0, which separates true modulo wrap from saturation. Writes aimed at read-only bytes, and a write with surplus bytes past its count, show whether storage obeys the count and the access type. Each select code is tried against its own address and a foreign one to show acknowledge versus silence. Changing one enable pin shows that the pin mirror and the gated enables both follow the pin.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int BYTE_W  = 8;
  localparam int REG_NUM = 8;
  localparam int IDX_W   = $clog2(REG_NUM);
  localparam int NUM_OUT = 12;
  localparam int BIT_CW  = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_INDEX, S_COUNT, S_WDATA, S_RDATA, S_SKIP
  } bus_state_t;

  function automatic logic [6:0] dev_addr(input logic [1:0] sel);
    case (sel)
      2'b00:   dev_addr = 7'h6E;
      2'b01:   dev_addr = 7'h6B;
      default: dev_addr = 7'h6A;
    endcase
  endfunction
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/smb_regs.sv
module smb_regs
  import smb_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                strap_bw,
  input  logic                strap_pll,
  input  logic [NUM_OUT-1:0]  oe_pin_n,
  input  logic                we,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [BYTE_W-1:0]   rd_data,
  output logic [BYTE_W-1:0]   count_reg,
  output logic [NUM_OUT-1:0]  en_bits,
  output logic                bw_bit,
  output logic                pll_bit
);
  localparam logic [BYTE_W-1:0] ID_REV_VEN = 8'h21;
  localparam logic [BYTE_W-1:0] ID_DEV_RST = 8'hC0;
  localparam logic [BYTE_W-1:0] CNT_RST    = 8'h07;
  localparam int HI_W = NUM_OUT - BYTE_W;

  logic [BYTE_W-1:0] mode_q, en_lo_q, dev_q, cnt_q;
  logic [HI_W-1:0]   en_hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= {strap_bw, strap_pll, 6'b0};
      en_lo_q <= '1;
      en_hi_q <= '1;
      dev_q   <= ID_DEV_RST;
      cnt_q   <= CNT_RST;
    end else if (we) begin
      case (wr_idx)
        3'd0: mode_q  <= wr_data;
        3'd1: en_lo_q <= wr_data;
        3'd2: en_hi_q <= wr_data[HI_W-1:0];
        3'd6: dev_q   <= wr_data;
        3'd7: cnt_q   <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_idx)
      3'd0:    rd_data = mode_q;
      3'd1:    rd_data = en_lo_q;
      3'd2:    rd_data = {{(BYTE_W-HI_W){1'b0}}, en_hi_q};
      3'd3:    rd_data = oe_pin_n[BYTE_W-1:0];
      3'd4:    rd_data = {{(BYTE_W-HI_W){1'b0}}, oe_pin_n[NUM_OUT-1:BYTE_W]};
      3'd5:    rd_data = ID_REV_VEN;
      3'd6:    rd_data = dev_q;
      default: rd_data = cnt_q;
    endcase
  end

  assign count_reg = cnt_q;
  assign en_bits   = {en_hi_q, en_lo_q};
  assign bw_bit    = mode_q[7];
  assign pll_bit   = mode_q[6];
endmodule

// File: rtl/smb_idx_slave.sv
module smb_idx_slave
  import smb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull,
  input  logic [1:0]         adr_code,
  input  logic [NUM_OUT-1:0] oe_pin_n,
  input  logic               strap_bw,
  input  logic               strap_pll,
  output logic [NUM_OUT-1:0] out_en,
  output logic               bw_low,
  output logic               pll_mode
);
  logic scl_s, sda_s, scl_d, sda_d;
  logic scl_rise, scl_fall, start_det, stop_det;

  smb_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q({scl_s, sda_s})
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_d;
  assign scl_fall  = ~scl_s &  scl_d;
  assign start_det =  scl_s &  scl_d &  sda_d & ~sda_s;
  assign stop_det  =  scl_s &  scl_d & ~sda_d &  sda_s;

  bus_state_t        state, nxt;
  logic [BIT_CW-1:0] bcnt;
  logic [BYTE_W-1:0] shreg, left;
  logic [IDX_W-1:0]  ptr;
  logic              host_ack;
  logic              busy;
  logic              reg_we;
  logic [BYTE_W-1:0] rd_data, count_reg;
  logic [NUM_OUT-1:0] en_bits;
  logic              bw_bit, pll_bit;

  assign busy   = (state != S_IDLE);
  assign reg_we = (state == S_WDATA) && scl_fall && (bcnt == 4'd8) && (left != '0);

  smb_regs u_regs (
    .clk(clk), .rst(rst), .strap_bw(strap_bw), .strap_pll(strap_pll),
    .oe_pin_n(oe_pin_n), .we(reg_we), .wr_idx(ptr), .wr_data(shreg),
    .rd_idx(ptr), .rd_data(rd_data), .count_reg(count_reg),
    .en_bits(en_bits), .bw_bit(bw_bit), .pll_bit(pll_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      nxt      <= S_IDLE;
      bcnt     <= '0;
      shreg    <= '0;
      left     <= '0;
      ptr      <= '0;
      host_ack <= 1'b0;
      sda_pull <= 1'b0;
    end else if (start_det) begin
      state    <= S_ADDR;
      bcnt     <= '0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      state    <= S_IDLE;
      bcnt     <= '0;
      sda_pull <= 1'b0;
    end else begin
      case (state)
        S_IDLE, S_SKIP: ;
        S_RDATA: begin
          if (scl_rise && bcnt <= 4'd8) begin
            if (bcnt == 4'd8) host_ack <= ~sda_s;
            bcnt <= bcnt + 1'b1;
          end else if (scl_fall) begin
            if (bcnt >= 4'd1 && bcnt <= 4'd7) begin
              shreg    <= {shreg[6:0], 1'b0};
              sda_pull <= ~shreg[6];
            end else if (bcnt == 4'd8) begin
              sda_pull <= 1'b0;
            end else if (bcnt == 4'd9) begin
              if (host_ack) begin
                shreg    <= rd_data;
                sda_pull <= ~rd_data[7];
                ptr      <= ptr + 1'b1;
                bcnt     <= '0;
              end else begin
                state <= S_SKIP;
              end
            end
          end
        end
        default: begin
          if (scl_rise && bcnt < 4'd8) begin
            shreg <= {shreg[6:0], sda_s};
            bcnt  <= bcnt + 1'b1;
          end else if (scl_fall && bcnt == 4'd8) begin
            bcnt     <= 4'd9;
            sda_pull <= 1'b1;
            case (state)
              S_ADDR: begin
                if (shreg[7:1] == dev_addr(adr_code)) begin
                  nxt <= shreg[0] ? S_RDATA : S_INDEX;
                end else begin
                  state    <= S_SKIP;
                  sda_pull <= 1'b0;
                end
              end
              S_INDEX: begin
                ptr <= shreg[IDX_W-1:0];
                nxt <= S_COUNT;
              end
              S_COUNT: begin
                left <= shreg;
                nxt  <= S_WDATA;
              end
              default: begin
                if (left != '0) begin
                  left <= left - 1'b1;
                  ptr  <= ptr + 1'b1;
                end
                nxt <= S_WDATA;
              end
            endcase
          end else if (scl_fall && bcnt == 4'd9) begin
            bcnt  <= '0;
            state <= nxt;
            if (nxt == S_RDATA) begin
              shreg    <= count_reg;
              sda_pull <= ~count_reg[7];
            end else begin
              sda_pull <= 1'b0;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_en   <= '0;
      bw_low   <= 1'b0;
      pll_mode <= 1'b0;
    end else begin
      out_en   <= en_bits & ~oe_pin_n;
      bw_low   <= bw_bit;
      pll_mode <= pll_bit;
    end
  end
endmodule

// File: rtl/smb_idx_slave_chk.sv
module smb_idx_slave_chk (
  input logic        clk,
  input logic        rst,
  input logic        scl_s,
  input logic        busy,
  input logic        sda_pull,
  input logic [11:0] oe_pin_n,
  input logic [11:0] out_en,
  input logic        strap_bw,
  input logic        strap_pll,
  input logic        bw_low,
  input logic        pll_mode
);
  // R10: data line moves only in the SCL low phase
  a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull) |-> !scl_s);

  // R10: released whenever no transfer is in progress
  a_r10_idle_release: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sda_pull);

  // R9: an enable is never high for a pin that was high the cycle before
  a_r9_pin_gates_enable: assert property (@(posedge clk) disable iff (rst)
    (out_en & $past(oe_pin_n)) == 12'h000);

  // R6: straps reach the mode outputs right after reset
  a_r6_strap_defaults: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && $past(rst, 2)) |=> (bw_low == $past(strap_bw, 2) && pll_mode == $past(strap_pll, 2)));
endmodule

bind smb_idx_slave smb_idx_slave_chk u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .busy(busy), .sda_pull(sda_pull),
  .oe_pin_n(oe_pin_n), .out_en(out_en), .strap_bw(strap_bw),
  .strap_pll(strap_pll), .bw_low(bw_low), .pll_mode(pll_mode)
);

// File: tb/smb_idx_slave_tb.sv
module smb_idx_slave_tb;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_h = 1'b1, sda_h = 1'b1;
  logic [1:0] sel = 2'b00;
  logic [11:0] oe_n = 12'h0A5;
  logic strap_bw = 1'b1, strap_pll = 1'b0;
  logic sda_pull, bw_low, pll_mode;
  logic [11:0] out_en;
  wire sda_line = sda_h & ~sda_pull;

  int total = 0, bad = 0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [9];
  logic rel_ok;

  always #2.5 clk = ~clk;

  smb_idx_slave u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_h), .sda_i(sda_line), .sda_pull(sda_pull),
    .adr_code(sel), .oe_pin_n(oe_n), .strap_bw(strap_bw), .strap_pll(strap_pll),
    .out_en(out_en), .bw_low(bw_low), .pll_mode(pll_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic hq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic h_start();
    sda_h = 1'b1; hq(); scl_h = 1'b1; hq(); sda_h = 1'b0; hq(); scl_h = 1'b0; hq();
  endtask

  task automatic h_stop();
    sda_h = 1'b0; hq(); scl_h = 1'b1; hq(); sda_h = 1'b1; hq(); hq();
  endtask

  task automatic h_wr(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; hq(); scl_h = 1'b1; hq(); hq(); scl_h = 1'b0; hq();
    end
    sda_h = 1'b1; hq(); scl_h = 1'b1; hq(); ack = ~sda_line; hq(); scl_h = 1'b0; hq();
  endtask

  task automatic h_rd(input logic nack, output logic [7:0] b);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hq(); scl_h = 1'b1; hq(); b[i] = sda_line; hq(); scl_h = 1'b0;
    end
    hq(); sda_h = nack; hq(); scl_h = 1'b1; hq(); hq(); scl_h = 1'b0; hq(); sda_h = 1'b1;
  endtask

  task automatic blk_wr(input logic [7:0] a8, input logic [7:0] idx, input logic [7:0] n,
                        input int nsend, output logic all_ack);
    logic k;
    h_start();
    h_wr(a8, k); all_ack = k;
    if (k) begin
      h_wr(idx, k); all_ack &= k;
      h_wr(n, k);   all_ack &= k;
      for (int i = 0; i < nsend; i++) begin
        h_wr(wbuf[i], k); all_ack &= k;
      end
    end
    h_stop();
  endtask

  task automatic blk_rd(input logic [7:0] a8, input logic [7:0] idx, input int nread,
                        output logic all_ack);
    logic k;
    h_start();
    h_wr(a8, k); all_ack = k;
    h_wr(idx, k); all_ack &= k;
    h_start();
    h_wr(a8 | 8'h01, k); all_ack &= k;
    for (int i = 0; i <= nread; i++) h_rd(i == nread, rbuf[i]);
    hq();
    rel_ok = ~sda_pull;
    h_stop();
  endtask

  task automatic t_reset();
    logic a;
    chk("R6 reset bw_low", bw_low, 1'b1);
    chk("R6 reset pll_mode", pll_mode, 1'b0);
    chk("R9 reset out_en gated by pins", out_en, 12'hF5A);
    chk("R10 idle release", sda_pull, 1'b0);
    blk_rd(8'hDC, 8'd0, 7, a);
    chk("R4 read acked", a, 1'b1);
    chk("R4 count byte first", rbuf[0], 8'h07);
    chk("R6 idx0 straps", rbuf[1], 8'h80);
    chk("R6 idx1 default", rbuf[2], 8'hFF);
    chk("R6 idx2 default", rbuf[3], 8'h0F);
    chk("R8 idx3 pins low", rbuf[4], 8'hA5);
    chk("R8 idx4 pins high", rbuf[5], 8'h00);
    chk("R7 idx5 id", rbuf[6], 8'h21);
    chk("R6 idx6 default", rbuf[7], 8'hC0);
    chk("R4 released after nack", rel_ok, 1'b1);
  endtask

  task automatic t_write();
    logic a;
    wbuf[0] = 8'h3C; wbuf[1] = 8'hF3;
    blk_wr(8'hDC, 8'd1, 8'd2, 2, a);
    chk("R2 write acked", a, 1'b1);
    repeat (4) @(posedge clk); #1;
    chk("R9 out_en after write", out_en, 12'h318);
    blk_rd(8'hDC, 8'd1, 2, a);
    chk("R2 idx1 stored", rbuf[1], 8'h3C);
    chk("R7 idx2 reserved bits zero", rbuf[2], 8'h03);
  endtask

  task automatic t_wrap();
    logic a;
    wbuf[0] = 8'h04; wbuf[1] = 8'h40;
    blk_wr(8'hDC, 8'd7, 8'd2, 2, a);
    chk("R5 wrap write acked", a, 1'b1);
    repeat (4) @(posedge clk); #1;
    chk("R9 bw_low from idx0", bw_low, 1'b0);
    chk("R9 pll_mode from idx0", pll_mode, 1'b1);
    blk_rd(8'hDC, 8'd6, 4, a);
    chk("R4 new count byte", rbuf[0], 8'h04);
    chk("R4 idx6", rbuf[1], 8'hC0);
    chk("R5 idx7", rbuf[2], 8'h04);
    chk("R5 wrapped idx0", rbuf[3], 8'h40);
    chk("R5 then idx1", rbuf[4], 8'h3C);
  endtask

  task automatic t_ro();
    logic a;
    wbuf[0] = 8'h00; wbuf[1] = 8'hFF; wbuf[2] = 8'h00;
    blk_wr(8'hDC, 8'd3, 8'd3, 3, a);
    chk("R7 ro write acked", a, 1'b1);
    blk_rd(8'hDC, 8'd3, 4, a);
    chk("R7 idx3 unchanged", rbuf[1], 8'hA5);
    chk("R7 idx4 unchanged", rbuf[2], 8'h00);
    chk("R7 idx5 unchanged", rbuf[3], 8'h21);
  endtask

  task automatic t_excess();
    logic a;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    blk_wr(8'hDC, 8'd6, 8'd1, 2, a);
    chk("R3 surplus acked", a, 1'b1);
    blk_rd(8'hDC, 8'd6, 2, a);
    chk("R2 idx6 stored", rbuf[1], 8'h11);
    chk("R3 idx7 untouched", rbuf[2], 8'h04);
  endtask

  task automatic t_addr();
    logic a;
    sel = 2'b01;
    wbuf[0] = 8'h77;
    blk_wr(8'hDC, 8'd6, 8'd1, 1, a);
    chk("R1 mid rejects DC", a, 1'b0);
    wbuf[0] = 8'h55;
    blk_wr(8'hD6, 8'd6, 8'd1, 1, a);
    chk("R1 mid accepts D6", a, 1'b1);
    blk_rd(8'hD6, 8'd6, 1, a);
    chk("R1 mid read acked", a, 1'b1);
    chk("R1 mid write stored, DC write dropped", rbuf[1], 8'h55);
    sel = 2'b10;
    blk_wr(8'hD6, 8'd6, 8'd0, 0, a);
    chk("R1 high rejects D6", a, 1'b0);
    chk("R1 released after mismatch", sda_pull, 1'b0);
    blk_wr(8'hD4, 8'd6, 8'd0, 0, a);
    chk("R1 high accepts D4", a, 1'b1);
    sel = 2'b00;
  endtask

  task automatic t_pins();
    logic a;
    oe_n = 12'h0AD;
    repeat (6) @(posedge clk); #1;
    chk("R9 pin disables output 3", out_en, 12'h310);
    blk_rd(8'hDC, 8'd3, 1, a);
    chk("R8 idx3 follows pin", rbuf[1], 8'hAD);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    repeat (5) @(posedge clk); #1;
    strap_bw = 1'b0; strap_pll = 1'b1;
    t_reset();
    t_write();
    t_wrap();
    t_ro();
    t_excess();
    t_addr();
    t_pins();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule